// File: doc/BRIEF.md
# Chained-Transfer SPI Master

This block is an SPI master driven by simple register strobes. A configuration write sets eight mode flags, the transfer length, a clock divisor and a chip-select mask. A write to the 32-bit data register then starts one transfer. Chip select can stay asserted from one transfer into the next, so a transaction can be built from several transfers, such as an 8-bit instruction followed by a 32-bit data word. Chip select is released only after a transfer that was configured as the last one.

Data is left-justified: in MSB-first mode the first bit on the wire is bit 31, so a short word has to sit in the top bits. When requested, the word held in the shift register at completion is presented for one cycle as a read-data event. The pads are modelled as value and output-enable pairs. This allows a 3-wire mode in which the data line turns around for reads, and an offline mode in which every pin floats.

Top module: `spi_chain_master`

## Requirements
- R1: `cfg_flags` bit meanings are: bit 0 offline, bit 1 last-transfer, bit 2 read-event, bit 3 chip-select active level, bit 4 SCK idle level, bit 5 sample on trailing edge, bit 6 LSB-first, bit 7 3-wire. The whole configuration is captured only while `busy` is low. A configuration write during a transfer has no effect.
- R2: A `dat_we` pulse while idle starts a transfer of `cfg_len`+1 bits. `busy` is then high for exactly N·D + ceil(D/2) cycles. A `dat_we` pulse while busy is ignored.
- R3: The divisor D is `cfg_div`+2, which gives 2 to 257. While idle, SCK sits at its idle level. During a transfer, SCK spends ceil(D/2) cycles at the idle level and floor(D/2) cycles at the opposite level in each bit. A closing hold of ceil(D/2) cycles is also spent at the idle level.
- R4: In MSB-first mode, bits leave from bit 31 downward. In LSB-first mode, bits leave from bit 0 upward.
- R5: With bit 5 clear, each input bit is sampled on the leading SCK edge and new data is driven on the trailing edge. With bit 5 set, the roles of the two edges are swapped.
- R6: While chip select is asserted, each `cs_o[i]` with `cfg_mask[i]`=1 is at the active level and every other pin is at the inactive level. While chip select is released, all pins are inactive.
- R7: Chip select asserts when a transfer starts. It is released at completion only if bit 1 was set, and otherwise stays asserted into the next transfer.
- R8: With bit 2 set, `rd_valid` is high for exactly one cycle, in the cycle after `busy` falls. At that point `rd_data` holds the shift register. In MSB-first mode this is (data<<N) with the received bits in the low N bits, first received highest. In LSB-first mode it is (data>>N) with the k-th received bit at position 32-N+k. With bit 2 clear, `rd_valid` stays low.
- R9: In 3-wire mode with bit 2 set, `mosi_oe` is low and input bits come from `mosi_i`. In 3-wire mode with bit 2 clear, the master drives the line as usual.
- R10: While bit 0 is set, `sck_oe`, `mosi_oe` and `cs_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_flags | input | 8 | Mode flags |
| cfg_len | input | 5 | Transfer length minus one |
| cfg_div | input | 8 | Clock divisor minus two |
| cfg_mask | input | 3 | Chip-select selection mask |
| dat_we | input | 1 | Data write strobe, starts a transfer |
| dat_wdata | input | 32 | Data word, left-justified |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle read-data event |
| rd_data | output | 32 | Shift-register contents |
| sck_o | output | 1 | Serial clock value |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Data-out value |
| mosi_oe | output | 1 | Data-out output enable |
| mosi_i | input | 1 | Data line as seen at the pad (3-wire input) |
| miso_i | input | 1 | Separate input line |
| cs_o | output | 3 | Chip-select values |
| cs_oe | output | 1 | Chip-select output enable |

## Verification
The bench sweeps every combination of SCK idle level, sampling edge and bit order across divisors 2, 3 and 5 and lengths 1, 8 and 32. The bench counts wire bits at its own sampling edges, so a design with an off-by-one bit count, a wrong edge, or the wrong byte end shows up as a wrong captured or returned word. Odd divisors check the placement of the extra cycle in the SCK period. Divisor 257 checks the top of the counter range, where a narrow counter would wrap. Further tests cover a chained transfer that must keep chip select asserted, writes made in the middle of a transfer that must change nothing, a 3-wire read that must release the data line, and offline mode that must float every pin.

// File: rtl/spi_cm_pkg.sv
`timescale 1ns/1ps
package spi_cm_pkg;
    localparam int FLAG_W      = 8;
    localparam int FL_OFFLINE  = 0;
    localparam int FL_LAST     = 1;
    localparam int FL_RDEVT    = 2;
    localparam int FL_CSPOL    = 3;
    localparam int FL_CPOL     = 4;
    localparam int FL_CPHA     = 5;
    localparam int FL_LSBF     = 6;
    localparam int FL_3WIRE    = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } spi_st_e;
endpackage

// File: rtl/spi_cm_shifter.sv
`timescale 1ns/1ps
module spi_cm_shifter #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] cur,
    input  logic          lsb_first,
    input  logic          rx_bit,
    output logic          tx_bit,
    output logic [DW-1:0] nxt
);
    // Bit that leaves next, and the register after one shift with rx_bit inserted
    assign tx_bit = lsb_first ? cur[0] : cur[DW-1];
    assign nxt    = lsb_first ? {rx_bit, cur[DW-1:1]} : {cur[DW-2:0], rx_bit};
endmodule

// File: rtl/spi_cm_pads.sv
`timescale 1ns/1ps
module spi_cm_pads
    import spi_cm_pkg::*;
#(
    parameter int NCS = 3
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic              sck_active,
    input  logic              tx_bit,
    input  logic              cs_act,
    input  logic [NCS-1:0]    mask,
    input  logic              miso_i,
    input  logic              mosi_i,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    output logic [NCS-1:0]    cs_o,
    output logic              cs_oe,
    output logic              rx_bit
);
    logic drive_en;
    logic line_turned;

    assign drive_en    = ~flags[FL_OFFLINE];
    assign line_turned = flags[FL_3WIRE] & flags[FL_RDEVT];

    assign sck_o   = flags[FL_CPOL] ^ sck_active;
    assign sck_oe  = drive_en;
    assign mosi_o  = tx_bit;
    assign mosi_oe = drive_en & ~line_turned;
    assign cs_oe   = drive_en;
    assign rx_bit  = flags[FL_3WIRE] ? mosi_i : miso_i;

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_o[g] = (cs_act & mask[g]) ? flags[FL_CSPOL] : ~flags[FL_CSPOL];
    end
endmodule

// File: rtl/spi_chain_master.sv
`timescale 1ns/1ps
module spi_chain_master
    import spi_cm_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NCS   = 3,
    parameter int DIV_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [FLAG_W-1:0]       cfg_flags,
    input  logic [$clog2(DW)-1:0]   cfg_len,
    input  logic [DIV_W-1:0]        cfg_div,
    input  logic [NCS-1:0]          cfg_mask,
    input  logic                    dat_we,
    input  logic [DW-1:0]           dat_wdata,
    output logic                    busy,
    output logic                    rd_valid,
    output logic [DW-1:0]           rd_data,
    output logic                    sck_o,
    output logic                    sck_oe,
    output logic                    mosi_o,
    output logic                    mosi_oe,
    input  logic                    mosi_i,
    input  logic                    miso_i,
    output logic [NCS-1:0]          cs_o,
    output logic                    cs_oe
);
    localparam int LEN_W = $clog2(DW);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        spi_st_e            st;
        logic               act;      // SCK in its non-idle half
        logic [CNT_W-1:0]   cnt;      // cycles left in current half, minus one
        logic [LEN_W-1:0]   bits;     // bits left after the current one
        logic               first;
        logic               rxbit;
        logic [DW-1:0]      sh;
        logic               cs_act;
        logic               rdv;
        logic [FLAG_W-1:0]  flags;
        logic [LEN_W-1:0]   len;
        logic [DIV_W-1:0]   div;
        logic [NCS-1:0]     mask;
    } regs_t;

    regs_t r_d, r_q;

    logic             tx_bit, rx_in;
    logic [DW-1:0]    sh_next;
    logic [CNT_W-1:0] dfull, idle_m1, act_m1;
    logic             cpha;

    spi_cm_shifter #(.DW(DW)) u_shift (
        .cur       (r_q.sh),
        .lsb_first (r_q.flags[FL_LSBF]),
        .rx_bit    (r_q.rxbit),
        .tx_bit    (tx_bit),
        .nxt       (sh_next)
    );

    spi_cm_pads #(.NCS(NCS)) u_pads (
        .flags      (r_q.flags),
        .sck_active (r_q.act),
        .tx_bit     (tx_bit),
        .cs_act     (r_q.cs_act),
        .mask       (r_q.mask),
        .miso_i     (miso_i),
        .mosi_i     (mosi_i),
        .sck_o      (sck_o),
        .sck_oe     (sck_oe),
        .mosi_o     (mosi_o),
        .mosi_oe    (mosi_oe),
        .cs_o       (cs_o),
        .cs_oe      (cs_oe),
        .rx_bit     (rx_in)
    );

    // Half lengths: idle-level half gets the extra cycle of an odd divisor
    assign dfull   = CNT_W'(r_q.div) + CNT_W'(2);
    assign idle_m1 = ((dfull + CNT_W'(1)) >> 1) - CNT_W'(1);
    assign act_m1  = (dfull >> 1) - CNT_W'(1);
    assign cpha    = r_q.flags[FL_CPHA];

    always_comb begin
        r_d     = r_q;
        r_d.rdv = 1'b0;
        if (cfg_we && r_q.st == ST_IDLE) begin
            r_d.flags = cfg_flags;
            r_d.len   = cfg_len;
            r_d.div   = cfg_div;
            r_d.mask  = cfg_mask;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (dat_we) begin
                    r_d.st     = ST_RUN;
                    r_d.act    = 1'b0;
                    r_d.cnt    = idle_m1;
                    r_d.bits   = r_q.len;
                    r_d.first  = 1'b1;
                    r_d.sh     = dat_wdata;
                    r_d.cs_act = 1'b1;
                end
            end
            ST_RUN: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (!r_q.act) begin
                    // leading edge
                    r_d.act = 1'b1;
                    r_d.cnt = act_m1;
                    if (!cpha) r_d.rxbit = rx_in;
                    if (cpha && !r_q.first) r_d.sh = sh_next;
                end else begin
                    // trailing edge
                    r_d.act   = 1'b0;
                    r_d.cnt   = idle_m1;
                    r_d.first = 1'b0;
                    if (cpha)  r_d.rxbit = rx_in;
                    if (!cpha) r_d.sh    = sh_next;
                    if (r_q.bits == '0) r_d.st   = ST_HOLD;
                    else                r_d.bits = r_q.bits - LEN_W'(1);
                end
            end
            ST_HOLD: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else begin
                    if (cpha) r_d.sh = sh_next;
                    r_d.st  = ST_IDLE;
                    r_d.rdv = r_q.flags[FL_RDEVT];
                    if (r_q.flags[FL_LAST]) r_d.cs_act = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign rd_valid = r_q.rdv;
    assign rd_data  = r_q.sh;

    // R1: configuration frozen during a transfer
    a_r1_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> $stable(r_q.flags) && $stable(r_q.div) && $stable(r_q.len));
    // R2: a started transfer loads the configured length
    a_r2_len_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (r_q.bits == r_q.len) && r_q.cs_act);
    // R3: SCK rests at its idle level whenever no transfer runs
    a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck_o == r_q.flags[FL_CPOL]));
    // R7: chip select is only dropped when a transfer completes
    a_r7_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.cs_act) |-> $fell(busy));
    // R8: read event is a single-cycle pulse right after completion
    a_r8_rdv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $fell(busy) ##1 !rd_valid);
    // R9: 3-wire read never drives the shared line
    a_r9_line_free: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.flags[FL_3WIRE] && r_q.flags[FL_RDEVT]) |-> !mosi_oe);
    // R10: offline floats every pin
    a_r10_offline: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.flags[FL_OFFLINE] |-> !(sck_oe || mosi_oe || cs_oe));
endmodule

// File: tb/spi_chain_master_tb.sv
`timescale 1ns/1ps
module spi_chain_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_flags = 8'h00;
    logic [4:0]  cfg_len = 5'd0;
    logic [7:0]  cfg_div = 8'd0;
    logic [2:0]  cfg_mask = 3'b000;
    logic        dat_we = 1'b0;
    logic [31:0] dat_wdata = 32'h0;
    logic        busy, rd_valid, sck_o, sck_oe, mosi_o, mosi_oe, cs_oe;
    logic [31:0] rd_data;
    logic [2:0]  cs_o;
    logic        mosi_i, miso_i;

    // bench-side slave
    logic [31:0] s_q = 32'h0;
    logic [31:0] m_cap = 32'h0;
    int          ncap = 0;
    logic        miso_zero = 1'b0;

    // current configuration as the bench knows it
    logic [7:0]  c_flags = 8'h00;
    int          c_n = 1, c_d = 2;
    logic [2:0]  c_mask = 3'b000;

    int n_cmp = 0, n_bad = 0;

    // results of last transfer
    int          r_cycles, r_idle;
    logic        r_rdv_now, r_rdv_after, r_cs_bad, r_oe_seen, r_mosi_oe_seen;
    logic [31:0] r_rd;

    always #2.5 clk = ~clk;

    assign miso_i = miso_zero ? 1'b0 : s_q[31];
    assign mosi_i = mosi_oe ? mosi_o : s_q[31];

    spi_chain_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flags(cfg_flags),
        .cfg_len(cfg_len), .cfg_div(cfg_div), .cfg_mask(cfg_mask),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_i(miso_i),
        .cs_o(cs_o), .cs_oe(cs_oe)
    );

    // slave samples on its sampling edge, then presents its next bit
    always @(sck_o) begin
        #0.1;
        if (busy === 1'b1 && sck_o == (c_flags[4] ^ !c_flags[5])) begin
            m_cap = {m_cap[30:0], mosi_o};
            s_q   = s_q << 1;
            ncap  = ncap + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [7:0] fl, input int n, input int d, input logic [2:0] m);
        @(negedge clk);
        cfg_flags = fl; cfg_len = 5'(n - 1); cfg_div = 8'(d - 2); cfg_mask = m;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        c_flags = fl; c_n = n; c_d = d; c_mask = m;
    endtask

    function automatic logic [2:0] cs_exp(input bit asserted);
        logic [2:0] v;
        for (int i = 0; i < 3; i++)
            v[i] = (asserted && c_mask[i]) ? c_flags[3] : ~c_flags[3];
        return v;
    endfunction

    task automatic run_xfer(input logic [31:0] data, input logic [31:0] sword, input bit inject);
        s_q = sword; m_cap = 32'h0; ncap = 0;
        r_cycles = 0; r_idle = 0; r_cs_bad = 0; r_oe_seen = 0; r_mosi_oe_seen = 0;
        @(negedge clk);
        dat_wdata = data; dat_we = 1'b1;
        @(negedge clk);
        dat_we = 1'b0;
        while (busy && r_cycles < 2000) begin
            r_cycles++;
            if (sck_o == c_flags[4]) r_idle++;
            if (cs_o != cs_exp(1'b1)) r_cs_bad = 1'b1;
            if (sck_oe || cs_oe) r_oe_seen = 1'b1;
            if (mosi_oe) r_mosi_oe_seen = 1'b1;
            if (inject && r_cycles == 3) begin
                dat_wdata = ~data; dat_we = 1'b1;
                cfg_flags = c_flags ^ 8'h10; cfg_we = 1'b1;
            end else begin
                dat_we = 1'b0; cfg_we = 1'b0; cfg_flags = c_flags;
            end
            @(negedge clk);
        end
        dat_we = 1'b0; cfg_we = 1'b0; cfg_flags = c_flags;
        r_rdv_now = rd_valid;
        r_rd = rd_data;
        @(negedge clk);
        r_rdv_after = rd_valid;
    endtask

    function automatic logic [31:0] tx_exp(input logic [31:0] data);
        logic [31:0] v = 32'h0;
        if (!c_flags[6]) v = data >> (32 - c_n);
        else for (int k = 0; k < c_n; k++) v[c_n - 1 - k] = data[k];
        return v;
    endfunction

    function automatic logic [31:0] rd_exp(input logic [31:0] data, input logic [31:0] sword);
        logic [63:0] t;
        logic [31:0] v;
        if (!c_flags[6]) begin
            t = ({32'h0, data} << c_n) | {32'h0, (sword >> (32 - c_n))};
            v = t[31:0];
        end else begin
            t = {32'h0, data} >> c_n;
            v = t[31:0];
            for (int k = 0; k < c_n; k++) v[32 - c_n + k] = sword[31 - k];
        end
        return v;
    endfunction

    // standard set of checks after a transfer
    task automatic check_xfer(input logic [31:0] data, input logic [31:0] sword, input string tag);
        int h1;
        logic [31:0] mask_n;
        h1 = (c_d + 1) / 2;
        mask_n = (c_n == 32) ? 32'hFFFF_FFFF : ((32'h1 << c_n) - 1);
        chk(r_cycles == c_n * c_d + h1, {tag, " R2 busy length"}, 64'(r_cycles), 64'(c_n * c_d + h1));
        chk(r_idle == (c_n + 1) * h1, {tag, " R3 idle-level cycles"}, 64'(r_idle), 64'((c_n + 1) * h1));
        chk(ncap == c_n, {tag, " R5 sample edges"}, 64'(ncap), 64'(c_n));
        chk((m_cap & mask_n) == tx_exp(data), {tag, " R4 wire order"}, 64'(m_cap & mask_n), 64'(tx_exp(data)));
        chk(!r_cs_bad, {tag, " R6 cs during transfer"}, 64'(r_cs_bad), 64'(0));
        if (c_flags[2]) begin
            chk(r_rdv_now && !r_rdv_after, {tag, " R8 event pulse"}, {r_rdv_now, r_rdv_after}, 64'b10);
            chk(r_rd == rd_exp(data, sword), {tag, " R8 read word"}, 64'(r_rd), 64'(rd_exp(data, sword)));
        end else begin
            chk(!r_rdv_now && !r_rdv_after, {tag, " R8 no event"}, {r_rdv_now, r_rdv_after}, 64'b00);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired R2 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, w;
        int it;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!busy && !rd_valid, "R2 reset idle", {busy, rd_valid}, 64'b00);
        chk(sck_o == 1'b0 && cs_o == 3'b111, "R6 reset pins", {sck_o, cs_o}, 64'b0111);
        chk(sck_oe && cs_oe && mosi_oe, "R10 reset drivers on", {sck_oe, cs_oe, mosi_oe}, 64'b111);

        // sweep: idle level x edge x bit order x divisor x length
        it = 0;
        for (int cp = 0; cp < 8; cp++) begin
            for (int di = 0; di < 3; di++) begin
                for (int li = 0; li < 3; li++) begin
                    automatic int dv = (di == 0) ? 2 : (di == 1) ? 3 : 5;
                    automatic int ln = (li == 0) ? 1 : (li == 1) ? 8 : 32;
                    automatic logic [7:0] fl = 8'h06 | 8'(cp << 4) | ((di == 1) ? 8'h08 : 8'h00);
                    set_cfg(fl, ln, dv, 3'(cp + 1));
                    d = 32'h13D7_B4E9 + 32'(it * 32'h0101_3377);
                    w = 32'hA5C3_0F96 ^ 32'(it * 32'h0F1E_2D3C);
                    run_xfer(d, w, 1'b0);
                    check_xfer(d, w, "sweep");
                    chk(cs_o == cs_exp(1'b0), "R7 release after last", 64'(cs_o), 64'(cs_exp(1'b0)));
                    it++;
                end
            end
        end

        // chained transaction: instruction then data, chip select kept
        set_cfg(8'h00, 8, 4, 3'b110);
        run_xfer(32'h1300_0000, 32'h0, 1'b0);
        check_xfer(32'h1300_0000, 32'h0, "chain first");
        chk(cs_o == 3'b001, "R7 cs held between transfers", 64'(cs_o), 64'b001);
        set_cfg(8'h06, 32, 4, 3'b110);
        run_xfer(32'hDEAD_BEEF, 32'h5A5A_C3C3, 1'b0);
        check_xfer(32'hDEAD_BEEF, 32'h5A5A_C3C3, "chain last");
        chk(cs_o == 3'b111, "R7 cs released at end", 64'(cs_o), 64'b111);

        // writes during a transfer are ignored
        set_cfg(8'h02, 32, 2, 3'b001);
        run_xfer(32'hC0FF_EE11, 32'h0, 1'b1);
        check_xfer(32'hC0FF_EE11, 32'h0, "busy writes");
        chk(!busy, "R2 data write while busy ignored", 64'(busy), 64'(0));
        chk(sck_o == 1'b0, "R1 config write while busy ignored", 64'(sck_o), 64'(0));

        // top of divisor range
        set_cfg(8'h06, 1, 257, 3'b100);
        run_xfer(32'h8000_0000, 32'h8000_0000, 1'b0);
        check_xfer(32'h8000_0000, 32'h8000_0000, "div257");

        // 3-wire read: line released, data from shared pin
        miso_zero = 1'b1;
        set_cfg(8'h86, 32, 3, 3'b001);
        run_xfer(32'h0, 32'h9E37_79B9, 1'b0);
        check_xfer(32'h0, 32'h9E37_79B9, "3wire read");
        chk(!r_mosi_oe_seen, "R9 line released during read", 64'(r_mosi_oe_seen), 64'(0));
        // 3-wire write: master drives
        set_cfg(8'h82, 8, 3, 3'b001);
        run_xfer(32'h8100_0000, 32'h0, 1'b0);
        check_xfer(32'h8100_0000, 32'h0, "3wire write");
        chk(r_mosi_oe_seen, "R9 line driven during write", 64'(r_mosi_oe_seen), 64'(1));
        miso_zero = 1'b0;

        // offline: every pin floats
        set_cfg(8'h03, 8, 2, 3'b111);
        chk(!(sck_oe || mosi_oe || cs_oe), "R10 offline idle", {sck_oe, mosi_oe, cs_oe}, 64'b000);
        run_xfer(32'hF000_0000, 32'h0, 1'b0);
        chk(!r_oe_seen && !r_mosi_oe_seen, "R10 offline during transfer", {r_oe_seen, r_mosi_oe_seen}, 64'b00);
        set_cfg(8'h00, 8, 2, 3'b000);
        chk(sck_oe && cs_oe && mosi_oe, "R10 drivers back on", {sck_oe, cs_oe, mosi_oe}, 64'b111);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule